// File: doc/BRIEF.md
# Fast-Page DRAM Controller with Idle CAS-before-RAS Refresh

This block connects a simple host command port to an asynchronous fast-page DRAM organised as 1M x 8. The 20-bit byte address goes out over 10 multiplexed address pins. The upper half is the row and is latched by the falling edge of the row strobe. The lower half is the column and is latched by the falling edge of the column strobe. The DRAM output enable is tied active, so the controller drives the data pins only while it writes.

The host can issue four commands: a single-byte read, a single-byte write, a 256-byte page read and a 256-byte page write. A page burst opens its row once. It then pulses the column strobe once per byte while only the low eight column bits count upward. Read bytes come back with a one-cycle valid pulse each. Page-write bytes are taken through a ready/valid pair, one byte per column cycle.

Whenever no command is waiting at the idle check, the controller runs exactly one CAS-before-RAS refresh cycle. After that refresh it passes through idle again. Strobe timing comes from clock-count parameters.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held and right after it, memRasN, memCasN and memWeN are high and rdValid and wrReady are low.
- R2: Address bits [19:10] are on memAddr when memRasN falls. Address bits [9:0] are on memAddr when memCasN falls.
- R3: A single read (cmdOp 2'b00) gives exactly one rdValid pulse, with rdData equal to the stored byte. rdValid is only ever high while busy is high.
- R4: A single write (cmdOp 2'b01) stores cmdWdata at the addressed byte. memWeN falls in the same cycle as memCasN and is never low unless both strobes are low.
- R5: The controller never drives memDq while memCasN is low and memWeN is high.
- R6: At each idle pass that finds no command, one refresh is issued. memCasN goes low at least one cycle before memRasN, memWeN stays high, and memRasN stays low for at least T_RAS cycles.
- R7: A command is accepted on a clock where cmdValid is high and busy is low, and busy is high on the next cycle. A command that arrives during a refresh waits until that refresh has finished in full.
- R8: A page read (cmdOp 2'b10) makes one row activation and 256 column strobes, and returns 256 bytes in increasing column order with 256 rdValid pulses.
- R9: A page write (cmdOp 2'b11) takes one byte per column strobe when wrReady and wrValid are both high. The beat stalls with the row still open while wrValid is low, and there is one row activation for the whole page.
- R10: Within a page, only column bits [7:0] count, wrapping from 0xFF to 0x00. Column bits [9:8] and the row stay fixed.
- R11: Every generated cycle keeps the RAS precharge of at least T_RP cycles, the RAS-to-CAS delay of at least T_RCD cycles, the CAS low width of at least T_CAS cycles and the CAS precharge of at least T_CP cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Host presents a command |
| cmdOp | input | 2 | 00 read, 01 write, 10 page read, 11 page write |
| cmdAddr | input | 20 | Byte address: row [19:10], column [9:0] |
| cmdWdata | input | 8 | Byte for a single write |
| busy | output | 1 | Controller is not at the idle check |
| wrReady | output | 1 | Page write takes a byte this cycle |
| wrValid | input | 1 | Host offers a page-write byte |
| wrData | input | 8 | Page-write byte |
| rdValid | output | 1 | One-cycle pulse per returned byte |
| rdData | output | 8 | Returned byte |
| memAddr | output | 10 | Multiplexed DRAM address |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write enable, active low |
| memDq | inout | 8 | DRAM data bus |

## Verification
A host command and an idle refresh compete for the same idle check. The bench provokes this by waiting until the column strobe has gone low with the row strobe still high, which is the first phase of a refresh, and presenting a read at that moment. The bench's DRAM model then has to see the refresh run to its full row-strobe width and be counted exactly once before the read's row activation. The read data must still be correct. The refresh count over a long idle stretch must also match the length of one idle pass.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [1:0] {
    OP_RD  = 2'b00,
    OP_WR  = 2'b01,
    OP_PRD = 2'b10,
    OP_PWR = 2'b11
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic rasN;
    logic casN;
    logic weN;
    logic load;     // latch a new command
    logic burst;    // new command is a page burst
    logic selCol;   // column half on the address pins
    logic drive;    // enable data drivers
    logic capture;  // sample the data bus
    logic step;     // advance column and beat count
    logic takeWr;   // latch a page-write byte
  } strobe_t;

endpackage

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
#(
  parameter int T_RP  = 2,
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_CP  = 1,
  parameter int T_CSR = 1,
  parameter int T_RAS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       wrValid,
  input  logic       lastBeat,
  output strobe_t    stb,
  output logic       busy,
  output logic       wrReady
);

  localparam int TW = $clog2(T_RP + T_RCD + T_CAS + T_CP + T_CSR + T_RAS + 1);

  typedef enum logic [2:0] {
    S_PRE, S_IDLE, S_ROW, S_ACT, S_CSET, S_CASLO, S_CBRC, S_CBRR
  } state_e;

  state_e        state, nextState;
  logic [TW-1:0] tmr;
  op_e           op;
  logic          tDone, isWrite;

  function automatic logic [TW-1:0] durOf(state_e s);
    case (s)
      S_PRE:   durOf = TW'(T_RP - 1);
      S_ACT:   durOf = TW'(T_RCD - 1);
      S_CSET:  durOf = TW'(T_CP - 1);
      S_CASLO: durOf = TW'(T_CAS - 1);
      S_CBRC:  durOf = TW'(T_CSR - 1);
      S_CBRR:  durOf = TW'(T_RAS - 1);
      default: durOf = '0;
    endcase
  endfunction

  assign tDone   = (tmr == '0);
  assign isWrite = op[0];

  always_comb begin
    nextState = state;
    case (state)
      S_PRE:   if (tDone) nextState = S_IDLE;
      S_IDLE:  nextState = cmdValid ? S_ROW : S_CBRC;
      S_ROW:   nextState = S_ACT;
      S_ACT:   if (tDone) nextState = S_CSET;
      S_CSET:  if (tDone && (op != OP_PWR || wrValid)) nextState = S_CASLO;
      S_CASLO: if (tDone) nextState = lastBeat ? S_PRE : S_CSET;
      S_CBRC:  if (tDone) nextState = S_CBRR;
      S_CBRR:  if (tDone) nextState = S_PRE;
      default: nextState = S_PRE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_PRE;
      tmr   <= TW'(T_RP - 1);
      op    <= OP_RD;
    end else begin
      state <= nextState;
      if (nextState != state) tmr <= durOf(nextState);
      else if (!tDone)        tmr <= tmr - 1'b1;
      if (state == S_IDLE && cmdValid) op <= op_e'(cmdOp);
    end
  end

  always_comb begin
    stb.rasN    = !(state inside {S_ACT, S_CSET, S_CASLO, S_CBRR});
    stb.casN    = !(state inside {S_CASLO, S_CBRC, S_CBRR});
    stb.weN     = !(state == S_CASLO && isWrite);
    stb.load    = (state == S_IDLE) && cmdValid;
    stb.burst   = cmdOp[1];
    stb.selCol  = (state == S_CSET) || (state == S_CASLO);
    stb.drive   = isWrite && stb.selCol;
    stb.capture = (state == S_CASLO) && tDone && !isWrite;
    stb.step    = (state == S_CASLO) && tDone && !lastBeat;
    wrReady     = (state == S_CSET) && tDone && (op == OP_PWR);
    stb.takeWr  = wrReady && wrValid;
    busy        = (state != S_IDLE);
  end

endmodule

// File: rtl/fpm_dp.sv
module fpm_dp
  import fpm_pkg::*;
#(
  parameter int ADDR_PINS = 10,
  parameter int DATA_W    = 8,
  parameter int PAGE_LEN  = 256
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                stb,
  input  logic [2*ADDR_PINS-1:0] cmdAddr,
  input  logic [DATA_W-1:0]      cmdWdata,
  input  logic [DATA_W-1:0]      wrData,
  output logic                   lastBeat,
  output logic                   rdValid,
  output logic [DATA_W-1:0]      rdData,
  output logic [ADDR_PINS-1:0]   memAddr,
  output logic                   memRasN,
  output logic                   memCasN,
  output logic                   memWeN,
  inout  wire  [DATA_W-1:0]      memDq
);

  localparam int BW = $clog2(PAGE_LEN);

  logic [ADDR_PINS-1:0] rowReg, colReg;
  logic [BW-1:0]        beatsLeft;
  logic [DATA_W-1:0]    wdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowReg    <= '0;
      colReg    <= '0;
      beatsLeft <= '0;
      wdReg     <= '0;
      rdData    <= '0;
      rdValid   <= 1'b0;
    end else begin
      rdValid <= stb.capture;
      if (stb.capture) rdData <= memDq;
      if (stb.load) begin
        rowReg    <= cmdAddr[2*ADDR_PINS-1:ADDR_PINS];
        colReg    <= cmdAddr[ADDR_PINS-1:0];
        beatsLeft <= stb.burst ? BW'(PAGE_LEN - 1) : '0;
        wdReg     <= cmdWdata;
      end
      if (stb.takeWr) wdReg <= wrData;
      if (stb.step) begin
        colReg[BW-1:0] <= colReg[BW-1:0] + 1'b1;
        beatsLeft      <= beatsLeft - 1'b1;
      end
    end
  end

  assign lastBeat = (beatsLeft == '0);
  assign memAddr  = stb.selCol ? colReg : rowReg;
  assign memRasN  = stb.rasN;
  assign memCasN  = stb.casN;
  assign memWeN   = stb.weN;
  assign memDq    = stb.drive ? wdReg : 'z;

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int ADDR_PINS = 10,
  parameter int DATA_W    = 8,
  parameter int PAGE_LEN  = 256,
  parameter int T_RP      = 2,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int T_CP      = 1,
  parameter int T_CSR     = 1,
  parameter int T_RAS     = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdValid,
  input  logic [1:0]             cmdOp,
  input  logic [2*ADDR_PINS-1:0] cmdAddr,
  input  logic [DATA_W-1:0]      cmdWdata,
  output logic                   busy,
  output logic                   wrReady,
  input  logic                   wrValid,
  input  logic [DATA_W-1:0]      wrData,
  output logic                   rdValid,
  output logic [DATA_W-1:0]      rdData,
  output logic [ADDR_PINS-1:0]   memAddr,
  output logic                   memRasN,
  output logic                   memCasN,
  output logic                   memWeN,
  inout  wire  [DATA_W-1:0]      memDq
);

  strobe_t stb;
  logic    lastBeat;

  fpm_ctrl #(
    .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_CP(T_CP), .T_CSR(T_CSR), .T_RAS(T_RAS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .wrValid(wrValid), .lastBeat(lastBeat), .stb(stb),
    .busy(busy), .wrReady(wrReady)
  );

  fpm_dp #(
    .ADDR_PINS(ADDR_PINS), .DATA_W(DATA_W), .PAGE_LEN(PAGE_LEN)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdAddr(cmdAddr),
    .cmdWdata(cmdWdata), .wrData(wrData), .lastBeat(lastBeat),
    .rdValid(rdValid), .rdData(rdData), .memAddr(memAddr),
    .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN), .memDq(memDq)
  );

endmodule

// File: rtl/fpm_dram_chk.sv
module fpm_dram_chk #(
  parameter int T_RP  = 2,
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_CP  = 1
) (
  input logic clk,
  input logic rstN,
  input logic memRasN,
  input logic memCasN,
  input logic memWeN,
  input logic busy,
  input logic cmdValid,
  input logic rdValid,
  input logic dataDrive
);

  logic [7:0] rasHigh, rasLow, casHigh, casLow;

  function automatic logic [7:0] sat(input logic [7:0] v);
    sat = (v == 8'hFF) ? v : v + 8'd1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasHigh <= '0; rasLow <= '0; casHigh <= '0; casLow <= '0;
    end else begin
      rasHigh <= memRasN ? sat(rasHigh) : '0;
      rasLow  <= memRasN ? '0 : sat(rasLow);
      casHigh <= memCasN ? sat(casHigh) : '0;
      casLow  <= memCasN ? '0 : sat(casLow);
    end
  end

  AST_PRECHARGE_MET: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memRasN) |-> rasHigh >= 8'(T_RP)); // R11
  AST_RAS_TO_CAS_MET: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(memCasN) && !memRasN) |-> rasLow >= 8'(T_RCD)); // R11
  AST_CAS_WIDTH_MET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCasN) |-> casLow >= 8'(T_CAS)); // R11
  AST_CAS_PRECHARGE_MET: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCasN) |-> casHigh >= 8'(T_CP)); // R11
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (!memCasN && memWeN) |-> !dataDrive); // R5
  AST_WE_WITH_CAS: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCasN && !memRasN)); // R4
  AST_CBR_CAS_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(memRasN) && !memCasN) |-> !$past(memCasN)); // R6
  AST_ACCEPT_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy) |=> busy); // R7
  AST_RDVALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> busy); // R3

endmodule

bind fpm_dram_ctrl fpm_dram_chk #(
  .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP)
) chk_i (
  .clk(clk), .rstN(rstN), .memRasN(memRasN), .memCasN(memCasN),
  .memWeN(memWeN), .busy(busy), .cmdValid(cmdValid), .rdValid(rdValid),
  .dataDrive(stb.drive)
);

// File: tb/fpm_dram_ctrl_tb_top.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_tb_top;

  localparam int T_RP = 2, T_RCD = 2, T_CAS = 2, T_CP = 1, T_CSR = 1, T_RAS = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'b00;
  logic [19:0] cmdAddr = '0;
  logic [7:0] cmdWdata = '0;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic       busy, wrReady, rdValid;
  logic [7:0] rdData;
  logic [9:0] memAddr;
  logic       memRasN, memCasN, memWeN;
  wire  [7:0] memDq;

  always #2.5 clk = ~clk;

  fpm_dram_ctrl dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdWdata(cmdWdata), .busy(busy), .wrReady(wrReady),
    .wrValid(wrValid), .wrData(wrData), .rdValid(rdValid), .rdData(rdData),
    .memAddr(memAddr), .memRasN(memRasN), .memCasN(memCasN),
    .memWeN(memWeN), .memDq(memDq)
  );

  // ---------------- DRAM model, sampled on falling clock edges ----------
  logic [7:0] mem [int];
  logic [7:0] modelOut = '0;
  logic       modelDrive = 1'b0;
  assign memDq = modelDrive ? modelOut : 8'bz;

  logic prevRas = 1'b1, prevCas = 1'b1, cbr = 1'b0;
  logic [9:0] lastRow = '0, lastCol = '0;
  int refreshCnt = 0, actCnt = 0, casCnt = 0, cbrLen = 0, lastCbrLen = 0;
  int cbrWeBad = 0, busConflict = 0, casLowLen = 0, rasHighLen = 0;
  int minCasLow = 99, minRasHigh = 99;

  always @(negedge clk) begin
    if (!rstN) begin
      prevRas = 1'b1; prevCas = 1'b1; cbr = 1'b0; modelDrive = 1'b0;
    end else begin
      if (prevRas && !memRasN) begin
        if (rasHighLen < minRasHigh) minRasHigh = rasHighLen;
        if (!memCasN) begin
          if (prevCas) cbrWeBad++;
          cbr = 1'b1; refreshCnt++; cbrLen = 0;
        end else begin
          lastRow = memAddr; actCnt++;
        end
      end
      if (!memRasN && cbr) begin
        cbrLen++;
        if (!memWeN) cbrWeBad++;
      end
      if (!prevRas && memRasN && cbr) begin
        lastCbrLen = cbrLen; cbr = 1'b0;
      end
      if (prevCas && !memCasN && !memRasN && !cbr) begin
        lastCol = memAddr; casCnt++;
        if (!memWeN) mem[int'({lastRow, memAddr})] = memDq;
      end
      if (!memCasN && !memRasN && !cbr) casLowLen++;
      if (!prevCas && memCasN && casLowLen > 0) begin
        if (casLowLen < minCasLow) minCasLow = casLowLen;
        casLowLen = 0;
      end
      rasHighLen = memRasN ? rasHighLen + 1 : 0;
      if (modelDrive && !memCasN && memWeN && memDq !== modelOut) busConflict++;
      modelDrive = !memCasN && !memRasN && memWeN && !cbr;
      if (modelDrive)
        modelOut = mem.exists(int'({lastRow, memAddr})) ? mem[int'({lastRow, memAddr})] : 8'h00;
      prevRas = memRasN; prevCas = memCasN;
    end
  end

  // ---------------- checking helpers -----------------------------------
  int nChecks = 0, nFail = 0;
  logic [7:0] rdBuf [256];
  int rdCnt;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  task automatic issue(input logic [1:0] op, input logic [19:0] addr, input logic [7:0] wd);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = addr; cmdWdata = wd;
    while (busy) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    rdCnt = 0;
    for (int i = 0; i < 3000; i++) begin
      if (rdValid) begin
        if (rdCnt < 256) rdBuf[rdCnt] = rdData;
        rdCnt++;
      end
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    pat = 8'((i * 3 + 1) ^ 8'h5C);
  endfunction

  // ---------------- scenarios ------------------------------------------
  task automatic tReset();
    repeat (2) @(negedge clk);
    check(memRasN && memCasN && memWeN, "R1 strobes in reset", {memRasN, memCasN, memWeN}, 3'b111);
    check(!rdValid && !wrReady, "R1 outputs in reset", {rdValid, wrReady}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(memRasN && memCasN && memWeN && !rdValid, "R1 after reset",
          {memRasN, memCasN, memWeN, rdValid}, 4'b1110);
  endtask

  task automatic tSingleWriteRead();
    int a0, c0;
    a0 = actCnt; c0 = casCnt;
    issue(2'b01, 20'h12345, 8'hA5); waitIdle();
    check(mem.exists(32'h12345) && mem[32'h12345] == 8'hA5, "R4 byte stored",
          mem.exists(32'h12345) ? mem[32'h12345] : 0, 8'hA5);
    check(lastRow == 10'h048, "R2 row half", lastRow, 10'h048);
    check(lastCol == 10'h345, "R2 column half", lastCol, 10'h345);
    check(actCnt - a0 == 1 && casCnt - c0 == 1, "R4 one strobe pair", casCnt - c0, 1);
    issue(2'b00, 20'h12345, 8'h00); waitIdle();
    check(rdCnt == 1, "R3 pulse count", rdCnt, 1);
    check(rdBuf[0] == 8'hA5, "R3 read data", rdBuf[0], 8'hA5);
  endtask

  task automatic tAddressEdges();
    issue(2'b01, 20'hFFFFF, 8'h5A); waitIdle();
    issue(2'b01, 20'h00000, 8'h3C); waitIdle();
    issue(2'b00, 20'hFFFFF, 8'h00); waitIdle();
    check(rdCnt == 1 && rdBuf[0] == 8'h5A, "R3 top address", rdBuf[0], 8'h5A);
    check(lastRow == 10'h3FF && lastCol == 10'h3FF, "R2 top address", {lastRow, lastCol}, 20'hFFFFF);
    issue(2'b00, 20'h00000, 8'h00); waitIdle();
    check(rdCnt == 1 && rdBuf[0] == 8'h3C, "R3 zero address", rdBuf[0], 8'h3C);
  endtask

  task automatic tIdleRefresh();
    int r0;
    r0 = refreshCnt;
    repeat (80) @(negedge clk);
    // one idle pass: idle 1 + cas-lead T_CSR + ras-low T_RAS + precharge T_RP = 8 cycles
    check(refreshCnt - r0 >= 9 && refreshCnt - r0 <= 11, "R6 refresh rate", refreshCnt - r0, 10);
    check(lastCbrLen >= T_RAS, "R6 refresh RAS width", lastCbrLen, T_RAS);
    check(cbrWeBad == 0, "R6 CAS lead and WE high", cbrWeBad, 0);
  endtask

  task automatic tCmdDuringRefresh();
    int r0, a0;
    for (int i = 0; i < 50; i++) begin
      if (!memCasN && memRasN) break;
      @(negedge clk);
    end
    r0 = refreshCnt; a0 = actCnt;
    issue(2'b00, 20'h12345, 8'h00); waitIdle();
    check(refreshCnt - r0 == 1, "R7 refresh completed once", refreshCnt - r0, 1);
    check(lastCbrLen >= T_RAS, "R7 refresh not cut short", lastCbrLen, T_RAS);
    check(actCnt - a0 == 1 && rdCnt == 1 && rdBuf[0] == 8'hA5, "R7 command served after refresh",
          rdBuf[0], 8'hA5);
  endtask

  task automatic tPageWrite();
    int a0, c0, idx, cyc, stalls, bad;
    a0 = actCnt; c0 = casCnt; idx = 0; cyc = 0; stalls = 0; bad = 0;
    issue(2'b11, {10'd7, 10'h1F0}, 8'h00);
    while (idx < 256 && cyc < 3000) begin
      wrValid = (cyc % 5 != 4);
      wrData  = pat(idx);
      if (wrReady && wrValid) idx++;
      if (wrReady && !wrValid) stalls++;
      cyc++;
      @(negedge clk);
    end
    wrValid = 1'b0;
    waitIdle();
    check(idx == 256, "R9 bytes consumed", idx, 256);
    check(stalls > 0, "R9 stall exercised", stalls, 1);
    check(actCnt - a0 == 1, "R9 single activation", actCnt - a0, 1);
    check(casCnt - c0 == 256, "R9 column strobes", casCnt - c0, 256);
    for (int i = 0; i < 256; i++) begin
      int k;
      k = int'({10'd7, 2'b01, 8'((8'hF0 + i) & 8'hFF)});
      if (!mem.exists(k) || mem[k] != pat(i)) bad++;
    end
    check(bad == 0, "R10 wrapped page contents", bad, 0);
    check(!mem.exists(int'({10'd7, 10'h200})) && !mem.exists(int'({10'd8, 10'h100})),
          "R10 no spill past block", 1, 0);
  endtask

  task automatic tPageRead();
    int a0, c0, bad;
    a0 = actCnt; c0 = casCnt; bad = 0;
    issue(2'b10, {10'd7, 10'h1F0}, 8'h00); waitIdle();
    check(rdCnt == 256, "R8 pulse count", rdCnt, 256);
    for (int i = 0; i < 256; i++) if (rdBuf[i] != pat(i)) bad++;
    check(bad == 0, "R8 page data order", bad, 0);
    check(actCnt - a0 == 1 && casCnt - c0 == 256, "R8 one row, 256 columns", casCnt - c0, 256);
    check(busConflict == 0, "R5 no contention on reads", busConflict, 0);
  endtask

  task automatic tTiming();
    check(minCasLow >= T_CAS, "R11 CAS width", minCasLow, T_CAS);
    check(minRasHigh >= T_RP, "R11 RAS precharge", minRasHigh, T_RP);
  endtask

  initial begin
    tReset();
    tSingleWriteRead();
    tAddressEdges();
    tIdleRefresh();
    tCmdDuringRefresh();
    tPageWrite();
    tPageRead();
    tTiming();
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

endmodule